// File: doc/BRIEF.md
# Scaled Bit Node Update Unit

This unit does the bit-side half of one iteration in a scaled min-sum LDPC decoder. It serves a variable node of degree three. In each cycle it accepts three check-to-bit messages and the soft value the channel delivered for that bit. From these it forms one extrinsic message per edge. Edge i receives the channel value plus the two check messages that did not arrive on edge i. That sum is scaled by three quarters and then clipped to the message width.

The same adder tree also yields a hard decision for the bit. That decision comes from the sign of the channel value plus all three check messages. A semi-parallel decoder holds an array of these units and feeds them from message memories. All outputs are registered, so a result appears one clock after its operands.

Messages are two's complement with two fraction bits. With the default five-bit width, one raw unit stands for 0.25. Message i sits in bits [i*MSG_W +: MSG_W] of the packed buses.

Top module: `vnode_scaled_update`

## Requirements
- R1: While rst_n is low, every extrinsic output and code_bit_o are 0.
- R2: Outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, which gives a latency of exactly one cycle.
- R3: The extrinsic output for edge i is derived from s_i. Here s_i is init_i plus the two check messages other than message i. Message i itself has no influence on output i.
- R4: The scaling of s_i is computed as floor(s_i/2) + floor(s_i/4), using arithmetic right shifts that round toward negative infinity. For example, s = -1 yields -2 and s = 1 yields 0.
- R5: Each extrinsic output saturates symmetrically to the range -(2^(MSG_W-1)-1) to +(2^(MSG_W-1)-1). For the default width this is -15 to +15 raw, or ±3.75. The most negative code, -16, is never produced.
- R6: code_bit_o is 1 when init_i plus all three check messages is below zero. It is 0 when that total is zero or positive.
- R7: Internal sums are wide enough that no intermediate value wraps. With every operand at -16, each output is -15 and the code bit is 1. With every operand at +15, each output is +15 and the code bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_msg_i | input | DEG*MSG_W | Packed check-to-bit messages, two's complement |
| init_i | input | MSG_W | Channel soft value for the bit, two's complement |
| ext_msg_o | output | DEG*MSG_W | Packed registered extrinsic bit-to-check messages |
| code_bit_o | output | 1 | Registered hard decision, 1 for a negative total |

## Verification
The bench builds the unit at its default size of three edges and five-bit messages. At that size the operand space is small enough to cover most of it directly. One sweep steps every combination of the channel value and two of the messages while a third message varies with them. A second sweep rotates which message is held to a pattern, so every output lane meets its full input range. Corner vectors at both extremes, together with checks of the output between edges, pin down the saturation points, the floor rounding of negative sums and the one-cycle latency.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
  // Width of an internal sum holding deg+1 operands of msg_w bits without wrap.
  function automatic int vnu_sum_width(input int msg_w, input int deg);
    return msg_w + $clog2(deg + 1);
  endfunction
endpackage

// File: rtl/vnu_sum_tree.sv
module vnu_sum_tree #(
  parameter int MSG_W = 5,
  parameter int DEG   = 3,
  parameter int SUM_W = 7
) (
  input  logic [DEG*MSG_W-1:0]    msgs_i,
  input  logic signed [MSG_W-1:0] init_i,
  output logic signed [SUM_W-1:0] total_o,
  output logic                    neg_o
);
  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = SUM_W'(init_i);
    for (int k = 0; k < DEG; k++) begin
      acc = acc + SUM_W'($signed(msgs_i[k*MSG_W +: MSG_W]));
    end
  end

  assign total_o = acc;
  assign neg_o   = acc[SUM_W-1];
endmodule

// File: rtl/vnu_edge_lane.sv
module vnu_edge_lane #(
  parameter int MSG_W = 5,
  parameter int SUM_W = 7
) (
  input  logic signed [SUM_W-1:0] total_i,
  input  logic signed [MSG_W-1:0] own_i,
  output logic signed [SUM_W-1:0] ext_sum_o,
  output logic signed [MSG_W-1:0] ext_o,
  output logic                    sat_o
);
  localparam logic signed [SUM_W-1:0] LIM = SUM_W'((1 << (MSG_W - 1)) - 1);

  // Floor-rounded three-quarter scaling using two arithmetic shifts.
  function automatic logic signed [SUM_W-1:0] scale34(input logic signed [SUM_W-1:0] x);
    return (x >>> 1) + (x >>> 2);
  endfunction

  logic signed [SUM_W-1:0] excl;
  logic signed [SUM_W-1:0] scaled;

  assign excl      = total_i - SUM_W'(own_i);
  assign scaled    = scale34(excl);
  assign ext_sum_o = excl;

  always_comb begin
    sat_o = 1'b0;
    if (scaled > LIM) begin
      ext_o = LIM[MSG_W-1:0];
      sat_o = 1'b1;
    end else if (scaled < -LIM) begin
      ext_o = -LIM[MSG_W-1:0];
      sat_o = 1'b1;
    end else begin
      ext_o = scaled[MSG_W-1:0];
    end
  end
endmodule

// File: rtl/vnode_scaled_update.sv
module vnode_scaled_update #(
  parameter int MSG_W = 5,
  parameter int DEG   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DEG*MSG_W-1:0] chk_msg_i,
  input  logic [MSG_W-1:0]     init_i,
  output logic [DEG*MSG_W-1:0] ext_msg_o,
  output logic                 code_bit_o
);
  import vnu_pkg::*;
  localparam int SUM_W = vnu_sum_width(MSG_W, DEG);
  localparam logic signed [MSG_W-1:0] OUT_LIM = MSG_W'((1 << (MSG_W - 1)) - 1);

  logic signed [SUM_W-1:0] total_w;
  logic                    neg_w;
  logic signed [MSG_W-1:0] lane_ext [DEG];
  logic signed [SUM_W-1:0] lane_sum [DEG];
  logic [DEG-1:0]          lane_sat;
  logic signed [MSG_W-1:0] ext_q [DEG];
  logic                    code_q;

  vnu_sum_tree #(.MSG_W(MSG_W), .DEG(DEG), .SUM_W(SUM_W)) u_tree (
    .msgs_i (chk_msg_i),
    .init_i ($signed(init_i)),
    .total_o(total_w),
    .neg_o  (neg_w)
  );

  for (genvar g = 0; g < DEG; g++) begin : g_lane
    vnu_edge_lane #(.MSG_W(MSG_W), .SUM_W(SUM_W)) u_lane (
      .total_i  (total_w),
      .own_i    ($signed(chk_msg_i[g*MSG_W +: MSG_W])),
      .ext_sum_o(lane_sum[g]),
      .ext_o    (lane_ext[g]),
      .sat_o    (lane_sat[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) ext_q[g] <= '0;
      else        ext_q[g] <= lane_ext[g];
    end

    assign ext_msg_o[g*MSG_W +: MSG_W] = ext_q[g];

    // R5
    ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q[g] != {1'b1, {(MSG_W-1){1'b0}}});

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(lane_sat[g])) |-> (ext_q[g] == OUT_LIM || ext_q[g] == -OUT_LIM));

    // R4
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(lane_sum[g]) >= 0) |->
        (ext_q[g] >= 0 && SUM_W'(ext_q[g]) <= $past(lane_sum[g])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= 1'b0;
    else        code_q <= neg_w;
  end
  assign code_bit_o = code_q;

  // R6
  code_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (code_bit_o == $past(neg_w)));

  // R2
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(chk_msg_i) == '0 && $past(init_i) == '0) |->
      (ext_msg_o == '0 && !code_bit_o));
endmodule

// File: tb/vnode_scaled_update_test.sv
module vnode_scaled_update_test;
  localparam int W = 5;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [D*W-1:0] chk = '0;
  logic [W-1:0] init = '0;
  logic [D*W-1:0] ext;
  logic code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  vnode_scaled_update #(.MSG_W(W), .DEG(D)) uut (
    .clk(clk), .rst_n(rst_n), .chk_msg_i(chk), .init_i(init),
    .ext_msg_o(ext), .code_bit_o(code)
  );

  always #5 clk = ~clk;

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic int floordiv(input int a, input int d);
    return (a >= 0) ? a / d : -((-a + d - 1) / d);
  endfunction

  function automatic int expect_ext(input int s);
    int r;
    int lim;
    lim = (1 << (W - 1)) - 1;
    r = floordiv(s, 2) + floordiv(s, 4);
    if (r > lim) r = lim;
    if (r < -lim) r = -lim;
    return r;
  endfunction

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Apply operands at a falling edge, then check after the following rising edge.
  task automatic apply_and_check(input int iv, input int m0, input int m1, input int m2, input string tag);
    int m [D];
    int tot;
    m[0] = m0; m[1] = m1; m[2] = m2;
    init = W'(iv);
    chk = {W'(m2), W'(m1), W'(m0)};
    @(posedge clk);
    @(negedge clk);
    tot = iv + m0 + m1 + m2;
    for (int k = 0; k < D; k++) begin
      check_int({tag, " ext R3"}, sx(ext[k*W +: W]), expect_ext(tot - m[k]));
    end
    check_int({tag, " code R6"}, int'(code), (tot < 0) ? 1 : 0);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    chk = {W'(7), W'(-3), W'(5)};
    init = W'(-9);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check_int("reset ext R1", int'(ext), 0);
    check_int("reset code R1", int'(code), 0);
    rst_n = 1'b1;

    // R4 floor rounding
    apply_and_check(-1, 0, 0, 0, "neg-one R4");
    check_int("neg-one R4 lane0", sx(ext[W-1:0]), -2);
    apply_and_check(1, 0, 0, 0, "pos-one R4");
    check_int("pos-one R4 lane0", sx(ext[W-1:0]), 0);

    // R7 extremes
    apply_and_check(-16, -16, -16, -16, "all-min R7");
    check_int("all-min R7 lane2", sx(ext[2*W +: W]), -15);
    check_int("all-min R7 code", int'(code), 1);
    apply_and_check(15, 15, 15, 15, "all-max R7");
    check_int("all-max R7 lane1", sx(ext[W +: W]), 15);
    check_int("all-max R7 code", int'(code), 0);

    // R6 zero total gives 0
    apply_and_check(4, -4, 2, -2, "zero-total R6");

    // R3 own message excluded: change only msg0, lane0 unchanged
    apply_and_check(3, 10, 2, -1, "excl-a R3");
    begin
      int keep;
      keep = sx(ext[W-1:0]);
      apply_and_check(3, -13, 2, -1, "excl-b R3");
      check_int("own msg ignored R3", sx(ext[W-1:0]), keep);
    end

    // R2 latency: output holds old value until the next rising edge
    apply_and_check(6, 6, 6, 6, "lat-a R2");
    chk = '0; init = '0;
    #2;
    check_int("hold before edge R2", sx(ext[W-1:0]), expect_ext(18));
    @(posedge clk); @(negedge clk);
    check_int("update after edge R2", int'(ext), 0);

    // Sweep: init, m0, m1 exhaustive; m2 patterned (R3 R4 R5)
    for (int a = -16; a < 16; a++)
      for (int b = -16; b < 16; b++)
        for (int c = -16; c < 16; c++)
          apply_and_check(a, b, c, ((a + 3*b + 5*c) % 32 + 48) % 32 - 16, "sweep1 R5");

    // Sweep with roles rotated: m1, m2 exhaustive, m0 patterned
    for (int a = -16; a < 16; a++)
      for (int b = -16; b < 16; b++)
        for (int c = -16; c < 16; c++)
          apply_and_check(a, ((7*a + b + 11*c) % 32 + 48) % 32 - 16, b, c, "sweep2 R4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule